// File: doc/BRIEF.md
# Serial Configuration and Record Readout Port

This block is the slave end of a three-wire serial link on a metering calculator. A host uses the link in two ways. It can send one-byte commands, each of which sets or clears exactly one bit in a bank of 112 configuration shadow latches. It can also select one of 28 stored measurement records and shift that record out. The 28 records form seven groups of four, indexed as group*4 + record. The data pin is bidirectional. It appears at the boundary as an input, an output and an output enable, and the pad ring ties them together.

The direction of a transfer is fixed when chip select falls. The level held on the serial clock pin while chip select is still high selects the mode: a low clock gives a command write, and a high clock gives a record read. A parallel write port lets the measurement datapath place 28-bit values into the record storage. The storage appends a parity nibble to each value. Permanent fuse programming is outside this block. The block only raises a one-cycle request when a configuration write commits while the write-enable latch is already set.

Named states: ST_IDLE (link quiet), ST_CMD (shifting a command byte), ST_IDX (shifting the record index), ST_SEND (driving record bits). Transitions: IDLE→CMD on chip-select fall with clock low. IDLE→IDX on chip-select fall with clock high. IDX→SEND on the eighth index clock. CMD/IDX/SEND→IDLE on chip-select rise.

Top module: `sercfg_link`

## Requirements
- R1: A command is shifted in most significant bit first on rising serial clock edges. Bit 7 is the value and bits 6:0 are the latch address. It is applied to that one latch when chip select rises after exactly eight clocks.
- R2: A command with any clock count other than eight leaves every latch unchanged.
- R3: A command addressing 112 to 127 changes no latch and raises no permanent-write request.
- R4: If any two consecutive rising clock edges of a command are fewer than MIN_PERIOD system cycles apart, the command is discarded.
- R5: The serial clock level while chip select is high selects the mode at chip-select fall: low for a command write, high for a record read. A read never changes a latch.
- R6: A read first shifts in an 8-bit index, most significant bit first. It then returns 32 bits least significant byte first, each byte most significant bit first, one bit advanced per rising clock. An index of 28 or more returns zero.
- R7: Bits 31:28 of a returned record equal the XOR of the seven 4-bit nibbles in bits 27:0, which hold the value last written for that index.
- R8: The record is captured at the eighth index clock. A datapath write to the same index during the read does not alter the bits returned.
- R9: perm_req pulses for one cycle, with perm_addr and perm_val, only for a committed in-range command when latch WE_ADDR (default 109) was already 1 before that command.
- R10: After reset, all latches and records are zero, the data pin is not driven and perm_req is low.
- R11: The data pin is driven only in the record-output phase, and is released once chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial bit clock; its level while deselected selects the mode |
| sdat_i | input | 1 | Data pin, input side |
| sdat_o | output | 1 | Data pin, output side |
| sdat_oe | output | 1 | Data pin output enable |
| cfg_bits | output | 112 | Configuration shadow latch contents |
| perm_req | output | 1 | One-cycle permanent-write request |
| perm_addr | output | 7 | Address of the requested permanent write |
| perm_val | output | 1 | Value of the requested permanent write |
| rec_wr_en | input | 1 | Record storage write strobe |
| rec_wr_sel | input | 5 | Record index to write (0 to 27) |
| rec_wr_data | input | 28 | Record data value |

## Verification
The hardest case to reach is a datapath update that lands while a read of the same record is in progress. The stimulus writes new data to the record partway through its 32 output bits. It expects the old value in that read and the new value in the next one. Rejection of fast clocking is reached by lowering MIN_PERIOD in the bench. A command is then clocked just below the limit, and the check confirms that a byte which would otherwise be valid changes nothing. Permanent-write requests are reached only after the write-enable latch has itself been set by a command.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
    localparam int REC_DATA_W = 28;
    localparam int REC_PAR_W  = 4;
    localparam int REC_W      = REC_DATA_W + REC_PAR_W;
    localparam int REC_NIBS   = REC_DATA_W / REC_PAR_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_IDX,
        ST_SEND
    } link_state_t;

    // XOR of all data nibbles; stored in the top nibble of a record.
    function automatic logic [REC_PAR_W-1:0] nib_parity(input logic [REC_DATA_W-1:0] d);
        logic [REC_PAR_W-1:0] acc;
        acc = '0;
        for (int n = 0; n < REC_NIBS; n++) begin
            acc = acc ^ d[n*REC_PAR_W +: REC_PAR_W];
        end
        return acc;
    endfunction
endpackage

// File: rtl/sercfg_sync.sv
module sercfg_sync #(
    parameter int   WIDTH  = 3,
    parameter int   STAGES = 2,
    parameter logic [WIDTH-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] lvl_prev
);
    logic [WIDTH-1:0] pipe [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[s] <= INIT;
                    else        pipe[s] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[s] <= INIT;
                    else        pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_prev <= INIT;
        else        lvl_prev <= pipe[STAGES-1];
    end

    assign lvl = pipe[STAGES-1];
endmodule

// File: rtl/sercfg_cfg_bank.sv
module sercfg_cfg_bank #(
    parameter int CFG_BITS = 112,
    parameter int ADDR_W   = 7,
    parameter int WE_ADDR  = 109
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit,
    input  logic [ADDR_W-1:0]   commit_addr,
    input  logic                commit_val,
    output logic [CFG_BITS-1:0] bits,
    output logic                perm_req,
    output logic [ADDR_W-1:0]   perm_addr,
    output logic                perm_val
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(CFG_BITS);

    logic in_range;
    assign in_range = {1'b0, commit_addr} < LIMIT;

    generate
        for (genvar i = 0; i < CFG_BITS; i++) begin : g_latch
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bits[i] <= 1'b0;
                end else if (commit && commit_addr == ADDR_W'(i)) begin
                    bits[i] <= commit_val;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            perm_req  <= 1'b0;
            perm_addr <= '0;
            perm_val  <= 1'b0;
        end else begin
            perm_req <= commit && in_range && bits[WE_ADDR];
            if (commit) begin
                perm_addr <= commit_addr;
                perm_val  <= commit_val;
            end
        end
    end
endmodule

// File: rtl/sercfg_rec_store.sv
module sercfg_rec_store
    import sercfg_pkg::*;
#(
    parameter int REC_COUNT = 28,
    parameter int WSEL_W    = 5,
    parameter int RSEL_W    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [WSEL_W-1:0]     wr_sel,
    input  logic [REC_DATA_W-1:0] wr_data,
    input  logic [RSEL_W-1:0]     rd_sel,
    output logic [REC_W-1:0]      rd_data
);
    logic [REC_W-1:0] mem [REC_COUNT];

    generate
        for (genvar e = 0; e < REC_COUNT; e++) begin : g_entry
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem[e] <= '0;
                end else if (wr_en && wr_sel == WSEL_W'(e)) begin
                    mem[e] <= {nib_parity(wr_data), wr_data};
                end
            end
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int e = 0; e < REC_COUNT; e++) begin
            if (rd_sel == RSEL_W'(e)) rd_data = mem[e];
        end
    end
endmodule

// File: rtl/sercfg_link.sv
module sercfg_link
    import sercfg_pkg::*;
#(
    parameter int CFG_BITS    = 112,
    parameter int ADDR_W      = 7,
    parameter int WE_ADDR     = 109,
    parameter int REC_COUNT   = 28,
    parameter int WSEL_W      = 5,
    parameter int MIN_PERIOD  = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  sclk,
    input  logic                  sdat_i,
    output logic                  sdat_o,
    output logic                  sdat_oe,
    output logic [CFG_BITS-1:0]   cfg_bits,
    output logic                  perm_req,
    output logic [ADDR_W-1:0]     perm_addr,
    output logic                  perm_val,
    input  logic                  rec_wr_en,
    input  logic [WSEL_W-1:0]     rec_wr_sel,
    input  logic [REC_DATA_W-1:0] rec_wr_data
);
    localparam int FRAME_W  = ADDR_W + 1;
    localparam int CNT_W    = $clog2(FRAME_W + 2);
    localparam int GAP_W    = $clog2(MIN_PERIOD + 1);
    localparam int BYTES    = REC_W / 8;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);
    localparam logic [GAP_W-1:0] GAP_MIN  = GAP_W'(MIN_PERIOD - 1);
    localparam logic [GAP_W-1:0] GAP_TOP  = GAP_W'(MIN_PERIOD);

    // ---------------- pin synchronisation ----------------
    logic [2:0] pin_lvl, pin_prev;

    sercfg_sync #(
        .WIDTH (3),
        .STAGES(SYNC_STAGES),
        .INIT  (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     ({cs_n, sclk, sdat_i}),
        .lvl     (pin_lvl),
        .lvl_prev(pin_prev)
    );

    logic cs_lvl, cs_rise, cs_fall, sclk_lvl, sclk_rise, data_bit;
    assign cs_lvl    = pin_lvl[2];
    assign cs_rise   = pin_lvl[2] & ~pin_prev[2];
    assign cs_fall   = ~pin_lvl[2] & pin_prev[2];
    assign sclk_lvl  = pin_lvl[1];
    assign sclk_rise = pin_lvl[1] & ~pin_prev[1];
    assign data_bit  = pin_prev[0];

    // ---------------- state machine ----------------
    link_state_t state_q, state_d;

    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] shift_in;
    logic [GAP_W-1:0]   gap_cnt;
    logic               seen_rise;
    logic               too_fast;
    logic [REC_W-1:0]   out_sr;
    logic               oe_q;

    logic               last_idx_bit;
    assign last_idx_bit = sclk_rise && (bit_cnt == CNT_FULL - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cs_fall) state_d = sclk_lvl ? ST_IDX : ST_CMD;
            ST_CMD:  if (cs_rise) state_d = ST_IDLE;
            ST_IDX: begin
                if (cs_rise)           state_d = ST_IDLE;
                else if (last_idx_bit) state_d = ST_SEND;
            end
            ST_SEND: if (cs_rise) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- command commit ----------------
    logic              commit;
    logic [ADDR_W-1:0] commit_addr;
    logic              commit_val;

    assign commit      = (state_q == ST_CMD) && cs_rise && (bit_cnt == CNT_FULL) && !too_fast;
    assign commit_addr = shift_in[ADDR_W-1:0];
    assign commit_val  = shift_in[FRAME_W-1];

    // ---------------- record fetch ----------------
    logic [FRAME_W-1:0] rd_sel;
    logic [REC_W-1:0]   rec_rd_data;
    logic [REC_W-1:0]   send_word;

    assign rd_sel = {shift_in[FRAME_W-2:0], data_bit};

    always_comb begin
        for (int b = 0; b < BYTES; b++) begin
            send_word[REC_W-1-8*b -: 8] = rec_rd_data[8*b +: 8];
        end
    end

    // ---------------- datapath / outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shift_in  <= '0;
            gap_cnt   <= '0;
            seen_rise <= 1'b0;
            too_fast  <= 1'b0;
            out_sr    <= '0;
            oe_q      <= 1'b0;
        end else begin
            if (sclk_rise)              gap_cnt <= '0;
            else if (gap_cnt != GAP_TOP) gap_cnt <= gap_cnt + 1'b1;

            unique case (state_q)
                ST_IDLE: begin
                    oe_q <= 1'b0;
                    if (cs_fall) begin
                        bit_cnt   <= '0;
                        seen_rise <= 1'b0;
                        too_fast  <= 1'b0;
                    end
                end
                ST_CMD: begin
                    if (sclk_rise && !cs_rise) begin
                        shift_in  <= {shift_in[FRAME_W-2:0], data_bit};
                        seen_rise <= 1'b1;
                        if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
                        if (seen_rise && gap_cnt < GAP_MIN) too_fast <= 1'b1;
                    end
                end
                ST_IDX: begin
                    if (sclk_rise && !cs_rise) begin
                        shift_in <= rd_sel;
                        bit_cnt  <= bit_cnt + 1'b1;
                        if (last_idx_bit) begin
                            out_sr <= send_word;
                            oe_q   <= 1'b1;
                        end
                    end
                end
                ST_SEND: begin
                    if (cs_rise)        oe_q   <= 1'b0;
                    else if (sclk_rise) out_sr <= {out_sr[REC_W-2:0], 1'b0};
                end
                default: oe_q <= 1'b0;
            endcase
        end
    end

    assign sdat_oe = oe_q;
    assign sdat_o  = oe_q & out_sr[REC_W-1];

    // ---------------- sub-blocks ----------------
    sercfg_cfg_bank #(
        .CFG_BITS(CFG_BITS),
        .ADDR_W  (ADDR_W),
        .WE_ADDR (WE_ADDR)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .commit_addr(commit_addr),
        .commit_val (commit_val),
        .bits       (cfg_bits),
        .perm_req   (perm_req),
        .perm_addr  (perm_addr),
        .perm_val   (perm_val)
    );

    sercfg_rec_store #(
        .REC_COUNT(REC_COUNT),
        .WSEL_W   (WSEL_W),
        .RSEL_W   (FRAME_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (rec_wr_en),
        .wr_sel (rec_wr_sel),
        .wr_data(rec_wr_data),
        .rd_sel (rd_sel),
        .rd_data(rec_rd_data)
    );
endmodule

// File: rtl/sercfg_link_chk.sv
module sercfg_link_chk
    import sercfg_pkg::*;
#(
    parameter int CFG_BITS = 112,
    parameter int WE_ADDR  = 109
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cs_lvl,
    input logic                sclk_rise,
    input link_state_t         state_q,
    input logic                commit,
    input logic [CFG_BITS-1:0] cfg_bits,
    input logic                perm_req,
    input logic                sdat_o,
    input logic                sdat_oe,
    input logic [REC_W-1:0]    rec_rd_data
);
    // R1: latches move only in the cycle after a commit
    assert_cfg_after_commit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bits != $past(cfg_bits)) |-> $past(commit));

    // R1: one command touches at most one latch
    assert_single_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cfg_bits ^ $past(cfg_bits)) <= 1);

    // R9: a permanent request needs the write-enable latch already set
    assert_perm_needs_we_R9: assert property (@(posedge clk) disable iff (!rst_n)
        perm_req |-> $past(cfg_bits[WE_ADDR]));

    // R7: any record presented by the storage carries consistent parity
    assert_parity_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rec_rd_data[REC_W-1 -: REC_PAR_W] == nib_parity(rec_rd_data[REC_DATA_W-1:0]));

    // R11: pin driven only while chip select was low
    assert_drive_selected_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sdat_oe |-> !$past(cs_lvl));

    // R11: pin driven only in the output phase
    assert_drive_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sdat_oe |-> (state_q == ST_SEND || $past(state_q) == ST_SEND || $past(state_q) == ST_IDX));

    // R6: output bit advances only after a clock rise
    assert_bit_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND && $past(state_q) == ST_SEND && !$past(sclk_rise)) |-> $stable(sdat_o));
endmodule

bind sercfg_link sercfg_link_chk #(
    .CFG_BITS(CFG_BITS),
    .WE_ADDR (WE_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_lvl     (cs_lvl),
    .sclk_rise  (sclk_rise),
    .state_q    (state_q),
    .commit     (commit),
    .cfg_bits   (cfg_bits),
    .perm_req   (perm_req),
    .sdat_o     (sdat_o),
    .sdat_oe    (sdat_oe),
    .rec_rd_data(rec_rd_data)
);

// File: tb/sercfg_link_test.sv
module sercfg_link_test;
    localparam int MINP = 16;
    localparam int H    = 20;   // slow half period, period 40 >= MINP
    localparam int HF   = 3;    // fast half period, period 6 < MINP

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1;
    logic         sclk = 1'b0;
    logic         sdat_i = 1'b0;
    logic         sdat_o, sdat_oe;
    logic [111:0] cfg_bits;
    logic         perm_req;
    logic [6:0]   perm_addr;
    logic         perm_val;
    logic         rec_wr_en = 1'b0;
    logic [4:0]   rec_wr_sel = '0;
    logic [27:0]  rec_wr_data = '0;

    always #2.5 clk = ~clk;

    sercfg_link #(.MIN_PERIOD(MINP)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdat_i(sdat_i),
        .sdat_o(sdat_o), .sdat_oe(sdat_oe), .cfg_bits(cfg_bits),
        .perm_req(perm_req), .perm_addr(perm_addr), .perm_val(perm_val),
        .rec_wr_en(rec_wr_en), .rec_wr_sel(rec_wr_sel), .rec_wr_data(rec_wr_data)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct { string req; logic [31:0] val; } exp_t;
    exp_t        exp_q[$];
    logic [31:0] act_q[$];

    int         perm_cnt = 0;
    logic [6:0] perm_last_addr = '0;
    logic       perm_last_val = 1'b0;
    always @(posedge clk) if (rst_n && perm_req) begin
        perm_cnt       <= perm_cnt + 1;
        perm_last_addr <= perm_addr;
        perm_last_val  <= perm_val;
    end

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: compares returned records against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (act_q.size() > 0) begin
                exp_t        e;
                logic [31:0] a;
                a = act_q.pop_front();
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R6 actual=%0h expected=<none>", a);
                end else begin
                    e = exp_q.pop_front();
                    check(e.req, {96'd0, a}, {96'd0, e.val});
                end
            end
        end
    end

    function automatic logic [31:0] model_rec(input logic [27:0] d);
        logic [3:0] p = 4'h0;
        for (int k = 0; k < 7; k++) p ^= d[4*k +: 4];
        return {p, d};
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cmd(input logic [15:0] pat, input int nbits, input int hp);
        sclk = 1'b0; wait_cyc(H);
        cs_n = 1'b0; wait_cyc(H);
        for (int b = nbits - 1; b >= 0; b--) begin
            sdat_i = pat[b];
            if (sdat_oe !== 1'b0) check("R11 oe during write", {127'd0, sdat_oe}, 128'd0);
            wait_cyc(hp); sclk = 1'b1;
            wait_cyc(hp); sclk = 1'b0;
        end
        wait_cyc(H);
        cs_n = 1'b1; wait_cyc(2 * H);
    endtask

    task automatic dsp_write(input int sel, input logic [27:0] d);
        rec_wr_sel = sel[4:0]; rec_wr_data = d; rec_wr_en = 1'b1;
        wait_cyc(1);
        rec_wr_en = 1'b0;
        wait_cyc(1);
    endtask

    task automatic read_rec(input logic [7:0] idx, input string req, input logic [31:0] expv,
                            input bit mid_upd, input logic [27:0] upd);
        logic [7:0] bytes [4];
        exp_t e;
        e.req = req; e.val = expv;
        exp_q.push_back(e);
        sclk = 1'b1; wait_cyc(H);
        cs_n = 1'b0; wait_cyc(H);
        for (int b = 7; b >= 0; b--) begin
            sclk = 1'b0; sdat_i = idx[b]; wait_cyc(H);
            sclk = 1'b1; wait_cyc(H);
        end
        for (int k = 0; k < 32; k++) begin
            sclk = 1'b0; wait_cyc(H);
            bytes[k / 8][7 - (k % 8)] = sdat_o;
            if (k == 0) check("R11 oe in output phase", {127'd0, sdat_oe}, 128'd1);
            if (mid_upd && k == 10) dsp_write(int'(idx), upd);
            sclk = 1'b1; wait_cyc(H);
        end
        cs_n = 1'b1; wait_cyc(2 * H);
        check("R11 released after deselect", {127'd0, sdat_oe}, 128'd0);
        act_q.push_back({bytes[3], bytes[2], bytes[1], bytes[0]});
        wait_cyc(2);
    endtask

    initial begin
        logic [111:0] ref_cfg;
        ref_cfg = '0;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(5);

        // R10 reset state
        check("R10 cfg after reset", {16'd0, cfg_bits}, 128'd0);
        check("R10 oe after reset", {127'd0, sdat_oe}, 128'd0);
        check("R10 perm after reset", {127'd0, perm_req}, 128'd0);

        // R1 basic writes, address boundaries
        write_cmd(16'h0085, 8, H); ref_cfg[5] = 1'b1;
        check("R1 set addr 5", {16'd0, cfg_bits}, {16'd0, ref_cfg});
        write_cmd(16'h0080, 8, H); ref_cfg[0] = 1'b1;
        write_cmd(16'h00EF, 8, H); ref_cfg[111] = 1'b1;
        check("R1 set addr 0 and 111", {16'd0, cfg_bits}, {16'd0, ref_cfg});
        write_cmd(16'h0005, 8, H); ref_cfg[5] = 1'b0;
        check("R1 clear addr 5", {16'd0, cfg_bits}, {16'd0, ref_cfg});

        // R2 wrong bit counts
        write_cmd(16'h0042, 7, H);
        check("R2 seven clocks discarded", {16'd0, cfg_bits}, {16'd0, ref_cfg});
        write_cmd(16'h0186, 9, H);
        check("R2 nine clocks discarded", {16'd0, cfg_bits}, {16'd0, ref_cfg});

        // R3 out-of-range address
        write_cmd(16'h00F8, 8, H);
        check("R3 addr 120 ignored", {16'd0, cfg_bits}, {16'd0, ref_cfg});

        // R4 too-fast clocking
        write_cmd(16'h0093, 8, HF);
        check("R4 fast command discarded", {16'd0, cfg_bits}, {16'd0, ref_cfg});
        write_cmd(16'h0093, 8, H); ref_cfg[19] = 1'b1;
        check("R4 same command at legal speed", {16'd0, cfg_bits}, {16'd0, ref_cfg});

        // R9 permanent request gating
        check("R9 no request while WE clear", 128'(perm_cnt), 128'd0);
        write_cmd(16'h00ED, 8, H); ref_cfg[109] = 1'b1;
        check("R9 setting WE issues no request", 128'(perm_cnt), 128'd0);
        write_cmd(16'h0087, 8, H); ref_cfg[7] = 1'b1;
        check("R9 request count with WE set", 128'(perm_cnt), 128'd1);
        check("R9 request address", {121'd0, perm_last_addr}, 128'd7);
        check("R9 request value", {127'd0, perm_last_val}, 128'd1);
        write_cmd(16'h00FA, 8, H);
        check("R3 out-of-range gives no request", 128'(perm_cnt), 128'd1);
        check("R1 cfg after WE phase", {16'd0, cfg_bits}, {16'd0, ref_cfg});

        // R6 / R7 record readout
        dsp_write(0, 28'h1234567);
        dsp_write(27, 28'hFEDCBA9);
        dsp_write(13, 28'h0A0B0C0);
        read_rec(8'd0, "R7 record 0", model_rec(28'h1234567), 1'b0, '0);
        read_rec(8'd27, "R6 record 27", model_rec(28'hFEDCBA9), 1'b0, '0);
        read_rec(8'd13, "R6 record 13", model_rec(28'h0A0B0C0), 1'b0, '0);
        read_rec(8'd5, "R6 unwritten record", 32'h0, 1'b0, '0);
        read_rec(8'd28, "R6 index 28 returns zero", 32'h0, 1'b0, '0);

        // R5 read with an index that looks like a command
        read_rec(8'h86, "R5 read index 0x86", 32'h0, 1'b0, '0);
        check("R5 read leaves latches", {16'd0, cfg_bits}, {16'd0, ref_cfg});

        // R8 update during read
        read_rec(8'd13, "R8 snapshot holds old value", model_rec(28'h0A0B0C0), 1'b1, 28'h5555AAA);
        read_rec(8'd13, "R8 next read sees update", model_rec(28'h5555AAA), 1'b0, '0);

        wait_cyc(20);
        check("R6 scoreboard drained", 128'(exp_q.size()), 128'd0);
        done = 1;
    end

    initial begin
        fork
            begin
                wait (done == 1);
            end
            begin
                repeat (150000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule